// File: doc/BRIEF.md
# TRIM Range Unmap Tracker

This block takes the payload of a host deallocate command as a stream of bytes, cuts it into 8-byte range entries and walks each range, clearing one bit per logical block in an on-chip mapped-bit table that covers a small logical space. A read lookup port sits beside it. The storage path presents an address together with the data it holds, and the block passes that data through only when the address is still mapped. Otherwise it returns all zeros. A host write to an address marks that address as mapped again.

The control path is a three-state machine. IDLE waits for a decoded entry. WALK clears one address per clock. DONE raises the completion pulse for one cycle. From IDLE, a decoded entry with a non-zero count moves to WALK. A zero-count entry either stays in IDLE or, if it closes the command, goes to DONE. WALK leaves when the count is used up, or at once when the current address passes the end of the supported space. It goes to DONE when the entry closes the command and to IDLE otherwise. DONE always returns to IDLE. Two counters run alongside: one for addresses cleared and one for addresses clipped off as out of range.

Top module: `trim_unmap_tracker`

## Requirements
- R1: After reset, `pl_ready` is 1, `cmd_done` is 0, both counters are 0, and every address reads as unmapped, so a lookup returns zero.
- R2: An entry is eight payload bytes sent least significant byte first. Bytes 0 to 5 form the 48-bit starting address and bytes 6 and 7 form the 16-bit block count. The entry is decoded after its eighth accepted byte.
- R3: An entry whose block count is zero changes no mapped bit and no counter.
- R4: An entry with start S and count N clears the mapped bits of addresses S to S+N-1 that fall inside the space. `unmap_count` grows by the number of those addresses.
- R5: Addresses of a range at or beyond `LBA_SPACE` are left alone and are added to `oor_count`.
- R6: A lookup with `rd_en` high gives `rd_valid` one cycle later. `rd_data` then equals the `rd_stored` value sampled with the lookup if the address was mapped, and zero if it was not.
- R7: A write (`wr_en` with `wr_lba`) marks the address as mapped, so later lookups pass the stored data through.
- R8: The walk clears one address per clock. `pl_ready` stays low from the cycle after an entry's last byte until the machine is back in IDLE. A command whose final entry covers N in-range addresses raises `cmd_done` N+2 cycles after that final byte is accepted.
- R9: `cmd_done` is a single-cycle pulse raised after the entry whose eighth byte carried `pl_last` has been processed. This holds when that entry has a count of zero, in which case it comes 2 cycles after the byte.
- R10: Parsing runs on without a break across 512-byte sector boundaries, so a command of more than 64 entries is handled in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_valid | input | 1 | Payload byte valid |
| pl_byte | input | 8 | Payload byte |
| pl_last | input | 1 | Marks the final byte of the command payload |
| pl_ready | output | 1 | Block accepts a payload byte this cycle |
| wr_en | input | 1 | Host write to an address |
| wr_lba | input | LBA_W | Address written |
| rd_en | input | 1 | Lookup request |
| rd_lba | input | LBA_W | Address looked up |
| rd_stored | input | DATA_W | Data held for that address |
| rd_valid | output | 1 | Lookup result valid |
| rd_data | output | DATA_W | Stored data, or zero if unmapped |
| cmd_done | output | 1 | One-cycle command completion pulse |
| unmap_count | output | CNT_W | Addresses cleared so far |
| oor_count | output | CNT_W | Addresses clipped as out of range |

## Verification
Several faults show up at the lookup port one cycle after the lookup that follows the command:
- A wrong mapped bit makes the block return zero where stored data was due, or leak stored data where zero was due.
- A byte-order or field-split error in the parser clears the wrong addresses.
- An off-by-one in the walk leaves a boundary address mapped or clears its neighbour.

Faults in the state machine appear earlier. A stuck or slow walk moves the `cmd_done` pulse away from the N+2 cycle point, or holds `pl_ready` low. A mishandled zero-count or out-of-range entry shows up in the two counters as soon as `cmd_done` fires.

// File: rtl/trim_pkg.sv
`timescale 1ns/1ps
package trim_pkg;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_WALK = 2'd1,
        W_DONE = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic [47:0] lba;
        logic [15:0] cnt;
        logic        last;
    } range_entry_t;

endpackage

// File: rtl/trim_entry_parser.sv
`timescale 1ns/1ps
module trim_entry_parser
    import trim_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_vld,
    input  logic [7:0]   byte_dat,
    input  logic         byte_last,
    input  logic         accept_ok,
    output logic         byte_rdy,
    output logic         ent_vld,
    output range_entry_t ent
);
    localparam int ENTRY_BYTES = 8;
    localparam int IDX_W       = $clog2(ENTRY_BYTES);

    logic [IDX_W-1:0] idx_q;
    logic [55:0]      hold_q;
    logic             fire;

    assign byte_rdy = accept_ok && !ent_vld;
    assign fire     = byte_vld && byte_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            hold_q  <= '0;
            ent_vld <= 1'b0;
            ent     <= '0;
        end else begin
            ent_vld <= 1'b0;
            if (fire) begin
                if (idx_q == IDX_W'(ENTRY_BYTES - 1)) begin
                    ent.lba  <= hold_q[47:0];
                    ent.cnt  <= {byte_dat, hold_q[55:48]};
                    ent.last <= byte_last;
                    ent_vld  <= 1'b1;
                    idx_q    <= '0;
                end else begin
                    hold_q[idx_q*8 +: 8] <= byte_dat;
                    idx_q                <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/trim_range_walker.sv
`timescale 1ns/1ps
module trim_range_walker
    import trim_pkg::*;
#(
    parameter int LBA_SPACE = 64,
    parameter int LBA_W     = 6,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_vld,
    input  range_entry_t     ent,
    output logic             idle,
    output logic             clr_en,
    output logic [LBA_W-1:0] clr_lba,
    output logic             done,
    output logic [CNT_W-1:0] unmap_cnt,
    output logic [CNT_W-1:0] oor_cnt
);
    localparam logic [48:0] SPACE_END = 49'(LBA_SPACE);

    walk_state_e state_q, state_d;
    logic [48:0] cur_q;
    logic [15:0] rem_q;
    logic        last_q;
    logic        in_rng;

    assign in_rng = cur_q < SPACE_END;

    // next-state and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (ent_vld) begin
                    if (ent.cnt == 16'd0) state_d = ent.last ? W_DONE : W_IDLE;
                    else                  state_d = W_WALK;
                end
            end
            W_WALK: begin
                if (!in_rng || rem_q == 16'd1) state_d = last_q ? W_DONE : W_IDLE;
            end
            W_DONE:  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        idle    = (state_q == W_IDLE);
        clr_en  = (state_q == W_WALK) && in_rng;
        clr_lba = cur_q[LBA_W-1:0];
        done    = (state_q == W_DONE);
    end

    // range position and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            rem_q     <= '0;
            last_q    <= 1'b0;
            unmap_cnt <= '0;
            oor_cnt   <= '0;
        end else begin
            if (state_q == W_IDLE && ent_vld) begin
                cur_q  <= {1'b0, ent.lba};
                rem_q  <= ent.cnt;
                last_q <= ent.last;
            end else if (state_q == W_WALK) begin
                if (in_rng) begin
                    cur_q     <= cur_q + 49'd1;
                    rem_q     <= rem_q - 16'd1;
                    unmap_cnt <= unmap_cnt + 1'b1;
                end else begin
                    oor_cnt <= oor_cnt + CNT_W'(rem_q);
                    rem_q   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/trim_map_bitmap.sv
`timescale 1ns/1ps
module trim_map_bitmap #(
    parameter int LBA_SPACE = 64,
    parameter int LBA_W     = 6,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [LBA_W-1:0]  clr_lba,
    input  logic              set_en,
    input  logic [LBA_W-1:0]  set_lba,
    input  logic              rd_en,
    input  logic [LBA_W-1:0]  rd_lba,
    input  logic [DATA_W-1:0] rd_stored,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [LBA_W:0] SPACE_END = (LBA_W+1)'(LBA_SPACE);

    logic [LBA_SPACE-1:0] map_q, map_d;
    logic                 hit;

    // clearing by the walk takes priority over a host write
    for (genvar i = 0; i < LBA_SPACE; i++) begin : g_bit
        assign map_d[i] = (clr_en && clr_lba == LBA_W'(i)) ? 1'b0 :
                          (set_en && set_lba == LBA_W'(i)) ? 1'b1 : map_q[i];
    end

    assign hit = ({1'b0, rd_lba} < SPACE_END) && map_q[rd_lba];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            map_q    <= map_d;
            rd_valid <= rd_en;
            rd_data  <= (rd_en && hit) ? rd_stored : '0;
        end
    end
endmodule

// File: rtl/trim_unmap_tracker.sv
`timescale 1ns/1ps
module trim_unmap_tracker
    import trim_pkg::*;
#(
    parameter int  LBA_SPACE = 64,
    parameter int  DATA_W    = 32,
    parameter int  CNT_W     = 32,
    localparam int LBA_W     = $clog2(LBA_SPACE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_valid,
    input  logic [7:0]        pl_byte,
    input  logic              pl_last,
    output logic              pl_ready,
    input  logic              wr_en,
    input  logic [LBA_W-1:0]  wr_lba,
    input  logic              rd_en,
    input  logic [LBA_W-1:0]  rd_lba,
    input  logic [DATA_W-1:0] rd_stored,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_done,
    output logic [CNT_W-1:0]  unmap_count,
    output logic [CNT_W-1:0]  oor_count
);
    logic             ent_vld;
    range_entry_t     ent;
    logic             walk_idle;
    logic             clr_en;
    logic [LBA_W-1:0] clr_lba;

    trim_entry_parser parser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (pl_valid),
        .byte_dat  (pl_byte),
        .byte_last (pl_last),
        .accept_ok (walk_idle),
        .byte_rdy  (pl_ready),
        .ent_vld   (ent_vld),
        .ent       (ent)
    );

    trim_range_walker #(
        .LBA_SPACE (LBA_SPACE),
        .LBA_W     (LBA_W),
        .CNT_W     (CNT_W)
    ) walker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_vld   (ent_vld),
        .ent       (ent),
        .idle      (walk_idle),
        .clr_en    (clr_en),
        .clr_lba   (clr_lba),
        .done      (cmd_done),
        .unmap_cnt (unmap_count),
        .oor_cnt   (oor_count)
    );

    trim_map_bitmap #(
        .LBA_SPACE (LBA_SPACE),
        .LBA_W     (LBA_W),
        .DATA_W    (DATA_W)
    ) bitmap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (clr_en),
        .clr_lba   (clr_lba),
        .set_en    (wr_en),
        .set_lba   (wr_lba),
        .rd_en     (rd_en),
        .rd_lba    (rd_lba),
        .rd_stored (rd_stored),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/trim_unmap_tracker_chk.sv
`timescale 1ns/1ps
module trim_unmap_tracker_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pl_ready,
    input logic              walk_idle,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_stored,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              cmd_done,
    input logic [CNT_W-1:0]  unmap_count,
    input logic [CNT_W-1:0]  oor_count
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r6_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r6_zero_or_stored: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == '0 || rd_data == $past(rd_stored)));

    a_r4_unmap_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid || !rd_valid |=> (unmap_count == $past(unmap_count) ||
                                   unmap_count == $past(unmap_count) + 1'b1));

    a_r5_oor_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_idle |=> oor_count >= $past(oor_count));

    a_r8_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_idle |-> !pl_ready);
endmodule

bind trim_unmap_tracker trim_unmap_tracker_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pl_ready    (pl_ready),
    .walk_idle   (walk_idle),
    .rd_en       (rd_en),
    .rd_stored   (rd_stored),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .cmd_done    (cmd_done),
    .unmap_count (unmap_count),
    .oor_count   (oor_count)
);

// File: tb/trim_unmap_tracker_tb_top.sv
`timescale 1ns/1ps
module trim_unmap_tracker_tb_top;
    localparam int SPACE = 64;
    localparam int DW    = 32;
    localparam int CW    = 32;
    localparam int AW    = $clog2(SPACE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pl_valid = 1'b0;
    logic [7:0]    pl_byte = '0;
    logic          pl_last = 1'b0;
    logic          pl_ready;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_lba = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_lba = '0;
    logic [DW-1:0] rd_stored = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          cmd_done;
    logic [CW-1:0] unmap_count;
    logic [CW-1:0] oor_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit ref_map [SPACE];
    int exp_unmap = 0;
    int exp_oor = 0;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #2 clk = ~clk;

    trim_unmap_tracker #(.LBA_SPACE(SPACE), .DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_byte(pl_byte),
        .pl_last(pl_last), .pl_ready(pl_ready), .wr_en(wr_en), .wr_lba(wr_lba),
        .rd_en(rd_en), .rd_lba(rd_lba), .rd_stored(rd_stored),
        .rd_valid(rd_valid), .rd_data(rd_data), .cmd_done(cmd_done),
        .unmap_count(unmap_count), .oor_count(oor_count)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected lookup results from the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected rd_valid", 64'd1, 64'd0);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, 64'(rd_data), 64'(e));
            end
        end
    end

    task automatic do_write(int lba);
        @(negedge clk);
        wr_en = 1'b1; wr_lba = AW'(lba);
        @(negedge clk);
        wr_en = 1'b0;
        ref_map[lba] = 1'b1;
    endtask

    task automatic do_read(int lba, logic [DW-1:0] stored, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_lba = AW'(lba); rd_stored = stored;
        exp_q.push_back(ref_map[lba] ? stored : '0);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // model the effect of one entry on the reference state
    task automatic model_entry(longint lba, int cnt);
        for (int k = 0; k < cnt; k++) begin
            if (lba + k < SPACE) begin
                ref_map[int'(lba + k)] = 1'b0;
                exp_unmap++;
            end else begin
                exp_oor++;
            end
        end
    endtask

    // send eight bytes, least significant first (R2)
    task automatic send_entry(logic [47:0] lba, logic [15:0] cnt, bit last);
        automatic logic [63:0] w = {cnt, lba};
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            pl_valid = 1'b1; pl_byte = w[b*8 +: 8]; pl_last = last && (b == 7);
            while (!pl_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        pl_valid = 1'b0; pl_last = 1'b0;
        model_entry(longint'(lba), int'(cnt));
    endtask

    // same, but returns how many negedges after the last byte cmd_done appears
    task automatic send_last_timed(logic [47:0] lba, logic [15:0] cnt, output int k, output bit rdy_seen);
        automatic logic [63:0] w = {cnt, lba};
        rdy_seen = 0;
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            pl_valid = 1'b1; pl_byte = w[b*8 +: 8]; pl_last = (b == 7);
            while (!pl_ready) @(negedge clk);
            @(posedge clk);
        end
        k = 1;
        @(negedge clk);
        pl_valid = 1'b0; pl_last = 1'b0;
        while (!cmd_done && k < 2000) begin
            if (pl_ready) rdy_seen = 1;
            k++;
            @(negedge clk);
        end
        if (pl_ready) rdy_seen = 1;
        model_entry(longint'(lba), int'(cnt));
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (cmd_done) return;
            @(negedge clk);
        end
        chk("R9 cmd_done timeout", 64'd0, 64'd1);
    endtask

    task automatic check_counts(string req);
        @(negedge clk);
        chk({req, " unmap_count"}, 64'(unmap_count), 64'(exp_unmap));
        chk({req, " oor_count"}, 64'(oor_count), 64'(exp_oor));
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        bit rs;
        for (int i = 0; i < SPACE; i++) ref_map[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pl_ready", 64'(pl_ready), 64'd1);
        chk("R1 cmd_done", 64'(cmd_done), 64'd0);
        chk("R1 unmap_count", 64'(unmap_count), 64'd0);
        chk("R1 oor_count", 64'(oor_count), 64'd0);
        do_read(5, 32'hDEAD_BEEF, "R1 unmapped after reset");

        // R7 writes map every address
        for (int i = 0; i < SPACE; i++) do_write(i);
        do_read(10, 32'h1234_5678, "R7 written address passes data");

        // R4/R8 single range, timed: N=4 -> done at N+2
        send_last_timed(48'd10, 16'd4, k, rs);
        chk("R8 done cycle for 4 LBAs", 64'(k), 64'd6);
        chk("R8 pl_ready low during walk", 64'(rs), 64'd0);
        check_counts("R4");
        do_read(9,  32'hAAAA_0009, "R4 below range stays mapped");
        do_read(10, 32'hAAAA_000A, "R4 first of range zero");
        do_read(13, 32'hAAAA_000D, "R4 last of range zero");
        do_read(14, 32'hAAAA_000E, "R4 after range stays mapped");

        // R3 zero-count entry skipped, then a real one
        send_entry(48'd20, 16'd0, 1'b0);
        send_entry(48'd30, 16'd1, 1'b1);
        wait_done();
        check_counts("R3");
        do_read(20, 32'hBBBB_0014, "R3 zero-count left address mapped");
        do_read(30, 32'hBBBB_001E, "R4 one-LBA range zero");

        // R9 zero-count last entry: done 2 cycles after, counters unchanged
        send_last_timed(48'd40, 16'd0, k, rs);
        chk("R9 done after zero-count last entry", 64'(k), 64'd2);
        check_counts("R9");
        do_read(40, 32'hCCCC_0028, "R3 zero-count last left mapped");

        // R5 range crossing the end of the space
        send_entry(48'd60, 16'd10, 1'b1);
        wait_done();
        check_counts("R5");
        do_read(59, 32'hDDDD_003B, "R5 before range mapped");
        do_read(63, 32'hDDDD_003F, "R5 top address cleared");

        // R2 high address bytes decoded: range far outside, LBA 0 untouched
        send_entry(48'h0100_0000_0000, 16'd3, 1'b1);
        wait_done();
        check_counts("R2");
        do_read(0, 32'hEEEE_0000, "R2 upper address bytes decoded");

        // R10 more than 64 entries in one command
        for (int e = 0; e < 68; e++) send_entry(48'(e), 16'd0, 1'b0);
        send_entry(48'd41, 16'd2, 1'b0);
        send_entry(48'd50, 16'h0001, 1'b1);
        wait_done();
        check_counts("R10");
        do_read(41, 32'hF000_0029, "R10 entry past first sector cleared");
        do_read(42, 32'hF000_002A, "R10 second LBA cleared");
        do_read(43, 32'hF000_002B, "R10 neighbour mapped");
        do_read(50, 32'hF000_0032, "R10 final entry cleared");

        // R7 rewrite restores pass-through
        do_write(11);
        do_read(11, 32'h0BAD_F00D, "R7 rewrite remaps address");

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule